// File: doc/BRIEF.md
# Greedy Crossbar Slot Reservation Unit

This unit books crossbar transfer time for a switch that has queues at both its inputs and its outputs, with a fabric running SPEEDUP times faster than the line. Each line time is divided into SPEEDUP crossbar sub-slots, and the unit advances one sub-slot per clock. A cell is presented as an (input, output) pair. In that same cycle the unit chooses a future sub-slot for it, so no per-slot matching pass is needed later.

Every input port and every output port has a circular availability map. The map covers HORIZON = SPEEDUP·(BURST+2·WIN+2) sub-slots. The unit models an ideal switch that queues only at its outputs. From that model it finds the line slot in which the cell would have left, called its ideal departure slot. It then books the earliest sub-slot that lies within WIN line slots after that departure slot and is free at both ends of the cell. If no such sub-slot exists, the cell is refused.

The booked pairs are stored by sub-slot. Each sub-slot's crossbar setting is driven out as that sub-slot comes round, and its map entries are then released for reuse.

Top module: `slot_allocator`

## Requirements
- R1: While reset is held and in the first cycle after it, grant_valid, grant_fail and every xfer_req bit are 0. The sub-slot counter restarts at index 0 and phase 0, and every map entry is free.
- R2: Each output keeps a backlog count q of admitted cells whose ideal departure slot lies after the current line slot. A cell admitted in line slot L gets ideal departure slot L+q+1 and adds one to q. In the last sub-slot of every line slot, q drops by one if it is nonzero. A refused cell leaves q unchanged.
- R3: Waits are counted in sub-slots from the arrival sub-slot, which has phase p within its line slot. A cell may only be booked at a wait between (q+2)·SPEEDUP−p and (q+WIN+2)·SPEEDUP−1−p inclusive. This range is the line slots from the ideal departure slot plus 1 through the ideal departure slot plus WIN.
- R4: The smallest wait in that range whose sub-slot is free at both the cell's input and its output is chosen. One cycle after the arrival, grant_valid=1, grant_fail=0, grant_wait holds the wait, and grant_slot holds (arrival index + wait) mod HORIZON.
- R5: A booking makes that sub-slot busy at its input and at its output in the same cycle. A later cell sharing either port cannot take it. No output is ever driven by two inputs in one sub-slot.
- R6: If no sub-slot in the range is free at both ports, the unit reports grant_valid=1 and grant_fail=1 one cycle later. It then books nothing and leaves the backlog unchanged.
- R7: One cycle after sub-slot index s is current, xfer_slot equals s. xfer_req has a 1 exactly for the inputs booked in s, and xfer_dest[i] gives the output for input i.
- R8: Once a sub-slot has been issued, its map entries are free again for every port. The same circular index can then be booked one horizon later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossbar sub-slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | A cell arrives this cycle |
| arr_in | input | OW | Input port of the arriving cell |
| arr_out | input | OW | Output port of the arriving cell |
| grant_valid | output | 1 | Result for the previous cycle's arrival |
| grant_fail | output | 1 | That arrival could not be booked |
| grant_slot | output | SW | Circular index of the booked sub-slot |
| grant_wait | output | SW | Sub-slots from arrival to the booked sub-slot |
| xfer_slot | output | SW | Circular index of the sub-slot being issued |
| xfer_req | output | N_PORTS | Per input, a transfer is booked in that sub-slot |
| xfer_dest | output | N_PORTS×OW | Per input, the output it connects to |

## Verification
The assertions assume that traffic is admissible in the sense the block relies on. Every port number is below N_PORTS, and the arrivals never push any output's backlog above BURST. That second condition is what keeps every booking range inside the circular horizon. The directed sequences send at most one cell per cycle and spread them across outputs, so the largest backlog stays at three. The refusal case runs on a second instance with a speedup of one and a one-slot window. There, two cells from the same input meet on the same sub-slot without breaking the backlog bound.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
package sa_pkg;

    // Bit width able to hold values 0..n-1, never less than one bit.
    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Circular horizon in sub-slots: covers the deepest booking range.
    function automatic int horizon_len(input int speedup, input int burst, input int win);
        return speedup * (burst + 2 * win + 2);
    endfunction

    typedef enum logic [1:0] {
        GRANT_NONE    = 2'd0,
        GRANT_OK      = 2'd1,
        GRANT_REFUSED = 2'd2
    } grant_kind_e;

endpackage

// File: rtl/sa_timebase.sv
`timescale 1ns/1ps
module sa_timebase
    import sa_pkg::*;
#(
    parameter int SPEEDUP = 3,
    parameter int HORIZON = 36,
    localparam int PW = width_of(SPEEDUP),
    localparam int SW = width_of(HORIZON)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase,
    output logic [SW-1:0] ptr,
    output logic          line_end
);

    assign line_end = (phase == PW'(SPEEDUP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            ptr   <= '0;
        end else begin
            phase <= line_end ? '0 : phase + 1'b1;
            ptr   <= (ptr == SW'(HORIZON - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // R1: the circular index never leaves the horizon
    a_r1_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < HORIZON);

endmodule

// File: rtl/sa_backlog.sv
`timescale 1ns/1ps
module sa_backlog
    import sa_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int SPEEDUP = 3,
    parameter int BURST   = 4,
    parameter int WIN     = 3,
    parameter int HORIZON = 36,
    localparam int OW = width_of(N_PORTS),
    localparam int PW = width_of(SPEEDUP),
    localparam int SW = width_of(HORIZON),
    localparam int QW = width_of(BURST + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic [PW-1:0] phase,
    input  logic [OW-1:0] arr_out,
    input  logic          admit,
    output logic [SW-1:0] win_lo,
    output logic [SW-1:0] win_hi
);

    logic [N_PORTS-1:0][QW-1:0] q_all;

    for (genvar o = 0; o < N_PORTS; o++) begin : g_q
        logic [QW-1:0] cnt;
        logic          take;

        assign take     = admit && (arr_out == OW'(o));
        assign q_all[o] = cnt;

        always_ff @(posedge clk) begin
            if (rst) cnt <= '0;
            else     cnt <= cnt + QW'(take) - QW'(line_end && (cnt != '0));
        end

        // R2: admissible traffic keeps every backlog within BURST
        a_r2_backlog_bound: assert property (@(posedge clk) disable iff (rst)
            int'(cnt) <= BURST);
    end

    // Booking range in sub-slots, relative to the arrival sub-slot.
    always_comb begin
        int qv;
        int lo;
        int hi;
        qv = int'(q_all[arr_out]);
        lo = (qv + 2) * SPEEDUP - int'(phase);
        hi = (qv + WIN + 2) * SPEEDUP - 1 - int'(phase);
        win_lo = SW'(lo);
        win_hi = SW'(hi);
    end

endmodule

// File: rtl/sa_avail.sv
`timescale 1ns/1ps
module sa_avail
    import sa_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int HORIZON = 36,
    localparam int OW = width_of(N_PORTS),
    localparam int SW = width_of(HORIZON)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] ptr,
    input  logic          arr_valid,
    input  logic [OW-1:0] arr_in,
    input  logic [OW-1:0] arr_out,
    input  logic [SW-1:0] win_lo,
    input  logic [SW-1:0] win_hi,
    output logic          found,
    output logic [SW-1:0] pick_off,
    output logic [SW-1:0] pick_idx
);

    logic [N_PORTS-1:0][HORIZON-1:0] in_free;
    logic [N_PORTS-1:0][HORIZON-1:0] out_free;

    // Earliest offset inside the range that is free at both ports.
    always_comb begin
        int idx;
        found    = 1'b0;
        pick_off = '0;
        pick_idx = '0;
        for (int j = 0; j < HORIZON; j++) begin
            idx = int'(ptr) + j;
            if (idx >= HORIZON) idx = idx - HORIZON;
            if (arr_valid && !found && j >= int'(win_lo) && j <= int'(win_hi)
                && in_free[arr_in][idx] && out_free[arr_out][idx]) begin
                found    = 1'b1;
                pick_off = SW'(j);
                pick_idx = SW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_free  <= '1;
            out_free <= '1;
        end else begin
            for (int p = 0; p < N_PORTS; p++) begin
                in_free[p][ptr]  <= 1'b1;
                out_free[p][ptr] <= 1'b1;
            end
            if (found) begin
                in_free[arr_in][pick_idx]   <= 1'b0;
                out_free[arr_out][pick_idx] <= 1'b0;
            end
        end
    end

    // R3: the chosen offset lies in the range the backlog side computed
    a_r3_pick_in_window: assert property (@(posedge clk) disable iff (rst)
        found |-> (pick_off >= win_lo) && (pick_off <= win_hi));

    // R3: the sub-slot being issued is never booked
    a_r3_never_current: assert property (@(posedge clk) disable iff (rst)
        found |-> pick_idx != ptr);

    // R5: a booking leaves both ports busy at that index
    a_r5_reserve_clears: assert property (@(posedge clk) disable iff (rst)
        found |=> !in_free[$past(arr_in)][$past(pick_idx)]
                  && !out_free[$past(arr_out)][$past(pick_idx)]);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_rel
        // R8: an issued sub-slot is free again for every port
        a_r8_release_frees: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> in_free[p][$past(ptr)] && out_free[p][$past(ptr)]);
    end

endmodule

// File: rtl/sa_sched.sv
`timescale 1ns/1ps
module sa_sched
    import sa_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int HORIZON = 36,
    localparam int OW = width_of(N_PORTS),
    localparam int SW = width_of(HORIZON)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SW-1:0]               ptr,
    input  logic                        wr_en,
    input  logic [SW-1:0]               wr_idx,
    input  logic [OW-1:0]               wr_in,
    input  logic [OW-1:0]               wr_out,
    output logic [SW-1:0]               xfer_slot,
    output logic [N_PORTS-1:0]          xfer_req,
    output logic [N_PORTS-1:0][OW-1:0]  xfer_dest
);

    logic [HORIZON-1:0][N_PORTS-1:0]         booked;
    logic [HORIZON-1:0][N_PORTS-1:0][OW-1:0] dest;

    always_ff @(posedge clk) begin
        if (rst) begin
            booked    <= '0;
            xfer_slot <= '0;
            xfer_req  <= '0;
            xfer_dest <= '0;
        end else begin
            xfer_slot    <= ptr;
            xfer_req     <= booked[ptr];
            xfer_dest    <= dest[ptr];
            booked[ptr]  <= '0;
            if (wr_en) begin
                booked[wr_idx][wr_in] <= 1'b1;
                dest[wr_idx][wr_in]   <= wr_out;
            end
        end
    end

    // R5: an input is never booked twice in one sub-slot
    a_r5_no_double_book: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !booked[wr_idx][wr_in]);

    for (genvar o = 0; o < N_PORTS; o++) begin : g_out
        logic [N_PORTS-1:0] hit;
        always_comb begin
            for (int i = 0; i < N_PORTS; i++)
                hit[i] = xfer_req[i] && (xfer_dest[i] == OW'(o));
        end
        // R5: each output hears at most one input per sub-slot
        a_r5_one_input_per_output: assert property (@(posedge clk) disable iff (rst)
            $countones(hit) <= 1);
    end

endmodule

// File: rtl/slot_allocator.sv
`timescale 1ns/1ps
module slot_allocator
    import sa_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int SPEEDUP = 3,
    parameter int BURST   = 4,
    parameter int WIN     = 3,
    localparam int HORIZON = horizon_len(SPEEDUP, BURST, WIN),
    localparam int OW = width_of(N_PORTS),
    localparam int PW = width_of(SPEEDUP),
    localparam int SW = width_of(HORIZON)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       arr_valid,
    input  logic [OW-1:0]              arr_in,
    input  logic [OW-1:0]              arr_out,
    output logic                       grant_valid,
    output logic                       grant_fail,
    output logic [SW-1:0]              grant_slot,
    output logic [SW-1:0]              grant_wait,
    output logic [SW-1:0]              xfer_slot,
    output logic [N_PORTS-1:0]         xfer_req,
    output logic [N_PORTS-1:0][OW-1:0] xfer_dest
);

    logic [PW-1:0] phase;
    logic [SW-1:0] ptr;
    logic          line_end;
    logic [SW-1:0] win_lo;
    logic [SW-1:0] win_hi;
    logic          found;
    logic [SW-1:0] pick_off;
    logic [SW-1:0] pick_idx;
    grant_kind_e   kind;

    sa_timebase #(.SPEEDUP(SPEEDUP), .HORIZON(HORIZON)) u_time (
        .clk(clk), .rst(rst), .phase(phase), .ptr(ptr), .line_end(line_end)
    );

    sa_backlog #(.N_PORTS(N_PORTS), .SPEEDUP(SPEEDUP), .BURST(BURST),
                 .WIN(WIN), .HORIZON(HORIZON)) u_backlog (
        .clk(clk), .rst(rst), .line_end(line_end), .phase(phase),
        .arr_out(arr_out), .admit(found), .win_lo(win_lo), .win_hi(win_hi)
    );

    sa_avail #(.N_PORTS(N_PORTS), .HORIZON(HORIZON)) u_avail (
        .clk(clk), .rst(rst), .ptr(ptr), .arr_valid(arr_valid),
        .arr_in(arr_in), .arr_out(arr_out), .win_lo(win_lo), .win_hi(win_hi),
        .found(found), .pick_off(pick_off), .pick_idx(pick_idx)
    );

    sa_sched #(.N_PORTS(N_PORTS), .HORIZON(HORIZON)) u_sched (
        .clk(clk), .rst(rst), .ptr(ptr), .wr_en(found), .wr_idx(pick_idx),
        .wr_in(arr_in), .wr_out(arr_out), .xfer_slot(xfer_slot),
        .xfer_req(xfer_req), .xfer_dest(xfer_dest)
    );

    always_comb begin
        if (!arr_valid) kind = GRANT_NONE;
        else if (found) kind = GRANT_OK;
        else            kind = GRANT_REFUSED;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= 1'b0;
            grant_fail  <= 1'b0;
            grant_slot  <= '0;
            grant_wait  <= '0;
        end else begin
            grant_valid <= (kind != GRANT_NONE);
            grant_fail  <= (kind == GRANT_REFUSED);
            grant_slot  <= (kind == GRANT_OK) ? pick_idx : '0;
            grant_wait  <= (kind == GRANT_OK) ? pick_off : '0;
        end
    end

    // R2: arriving port numbers stay below N_PORTS
    a_r2_ports_in_range: assert property (@(posedge clk) disable iff (rst)
        arr_valid |-> (int'(arr_in) < N_PORTS) && (int'(arr_out) < N_PORTS));

    // R4: reported index equals arrival index plus wait, modulo the horizon
    a_r4_slot_matches_wait: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !grant_fail) |->
            int'(grant_slot) == (int'($past(ptr)) + int'(grant_wait)) % HORIZON);

    // R6: a refusal is always a reported result
    a_r6_fail_is_result: assert property (@(posedge clk) disable iff (rst)
        grant_fail |-> grant_valid);

endmodule

// File: tb/test_slot_allocator.sv
`timescale 1ns/1ps
module test_slot_allocator;

    localparam int N  = 4;
    localparam int H  = 36;   // main instance: SPEEDUP 3, BURST 4, WIN 3
    localparam int SW = 6;
    localparam int FSW = 3;   // refusal instance: SPEEDUP 1, BURST 4, WIN 1, horizon 8

    // Arrival vectors applied on consecutive cycles from the first cycle after reset.
    localparam int NV = 6;
    localparam int V_IN   [NV] = '{0, 1, 0, 2, 0, 1};
    localparam int V_OUT  [NV] = '{0, 0, 1, 0, 0, 2};
    localparam int V_WAIT [NV] = '{6, 8, 5, 9, 11, 5};
    // Expected transfers: sub-slot, input, output.
    localparam int NX = 7;
    localparam int X_T [NX] = '{6, 7, 9, 10, 12, 15, 42};
    localparam int X_I [NX] = '{0, 0, 1, 1, 2, 0, 0};
    localparam int X_O [NX] = '{0, 1, 0, 2, 0, 0, 0};
    // Refusal instance vectors.
    localparam int NF = 4;
    localparam int F_IN   [NF] = '{1, 0, 0, 2};
    localparam int F_OUT  [NF] = '{0, 0, 1, 1};
    localparam int F_WAIT [NF] = '{2, 3, 0, 2};
    localparam int F_FAIL [NF] = '{0, 0, 1, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic                a_valid = 1'b0;
    logic [1:0]          a_in = '0;
    logic [1:0]          a_out = '0;
    logic                g_valid, g_fail;
    logic [SW-1:0]       g_slot, g_wait, x_slot;
    logic [N-1:0]        x_req;
    logic [N-1:0][1:0]   x_dest;

    logic                f_valid = 1'b0;
    logic [1:0]          f_in = '0;
    logic [1:0]          f_out = '0;
    logic                fg_valid, fg_fail;
    logic [FSW-1:0]      fg_slot, fg_wait, fx_slot;
    logic [N-1:0]        fx_req;
    logic [N-1:0][1:0]   fx_dest;

    slot_allocator #(.N_PORTS(N), .SPEEDUP(3), .BURST(4), .WIN(3)) i_slot_allocator (
        .clk(clk), .rst(rst), .arr_valid(a_valid), .arr_in(a_in), .arr_out(a_out),
        .grant_valid(g_valid), .grant_fail(g_fail), .grant_slot(g_slot),
        .grant_wait(g_wait), .xfer_slot(x_slot), .xfer_req(x_req), .xfer_dest(x_dest)
    );

    slot_allocator #(.N_PORTS(N), .SPEEDUP(1), .BURST(4), .WIN(1)) i_slot_allocator_s1 (
        .clk(clk), .rst(rst), .arr_valid(f_valid), .arr_in(f_in), .arr_out(f_out),
        .grant_valid(fg_valid), .grant_fail(fg_fail), .grant_slot(fg_slot),
        .grant_wait(fg_wait), .xfer_slot(fx_slot), .xfer_req(fx_req), .xfer_dest(fx_dest)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "grant_valid in reset", int'(g_valid), 0);
        chk("R1", "xfer_req in reset", int'(x_req), 0);
        chk("R1", "refusal instance grant in reset", int'(fg_valid), 0);

        for (int j = 0; j <= 50; j++) begin
            int pj;
            int er;
            if (j > 0) begin
                pj = j - 1;
                // Grants for the arrival of cycle pj.
                if (pj < NV) begin
                    chk("R2 R3 R4 R5", "grant_valid", int'(g_valid), 1);
                    chk("R4", "grant_fail", int'(g_fail), 0);
                    chk("R2 R3 R4 R5", "grant_wait", int'(g_wait), V_WAIT[pj]);
                    chk("R4", "grant_slot", int'(g_slot), (pj + V_WAIT[pj]) % H);
                end else if (pj == 36) begin
                    chk("R8", "reuse wait", int'(g_wait), 6);
                    chk("R8", "reuse slot", int'(g_slot), 6);
                end else begin
                    chk("R1 R4", "no grant without arrival", int'(g_valid), 0);
                end
                // Transfer issue for sub-slot pj.
                er = 0;
                for (int k = 0; k < NX; k++)
                    if (X_T[k] == pj) er = er | (1 << X_I[k]);
                chk("R7", "xfer_slot", int'(x_slot), pj % H);
                chk("R7 R8", "xfer_req", int'(x_req), er);
                for (int k = 0; k < NX; k++)
                    if (X_T[k] == pj) chk("R7", "xfer_dest", int'(x_dest[X_I[k]]), X_O[k]);
                // Refusal instance.
                if (pj < NF) begin
                    chk("R6", "s1 grant_valid", int'(fg_valid), 1);
                    chk("R6", "s1 grant_fail", int'(fg_fail), F_FAIL[pj]);
                    if (F_FAIL[pj] == 0)
                        chk("R2 R3 R6", "s1 grant_wait", int'(fg_wait), F_WAIT[pj]);
                end
            end
            // Stimulus for cycle j.
            rst = 1'b0;
            if (j < NV) begin
                a_valid = 1'b1; a_in = 2'(V_IN[j]); a_out = 2'(V_OUT[j]);
            end else if (j == 36) begin
                a_valid = 1'b1; a_in = 2'd0; a_out = 2'd0;
            end else begin
                a_valid = 1'b0; a_in = '0; a_out = '0;
            end
            if (j < NF) begin
                f_valid = 1'b1; f_in = 2'(F_IN[j]); f_out = 2'(F_OUT[j]);
            end else begin
                f_valid = 1'b0; f_in = '0; f_out = '0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule